// File: doc/BRIEF.md
# Bit-Slice Pattern Match Engine

This block watches a set of already-synchronized input channels and raises a match output when a programmable boolean expression over them is true. The expression is built from eight slices. Each slice selects one channel and tests it for a level, an edge, an event or a constant. Runs of neighbouring slices are ANDed into product terms, and each run is closed by a per-slice end-point flag. The product terms are then ORed.

Three write-only registers program the engine through a simple write port. The source register selects the channel for each slice. The configuration register holds each slice's condition code and the end-point flags. The control register chooses whether the interrupt path uses the pattern result or the per-channel interrupts, and it enables an event pulse. Edge-type conditions are sticky inside a slice, so a term can combine an edge seen earlier with a level present now. Per-term status is driven combinationally from the current inputs.

Top module: `pm_engine`

## Requirements
- R1: After reset all registers are zero. Every slice then holds condition 0 and only slice 7 is an end point, so `termStatus` is 8'h80, `matchOut` is 1, and `patternSel` and `eventPulse` are 0.
- R2: A write with `wrAddr`=0 sets the channel of slice n from `wrData[8+3n +: 3]`.
- R3: A write with `wrAddr`=1 sets the condition of slice n from `wrData[8+3n +: 3]`. Code 0 always holds, code 6 never holds, code 4 holds while the selected channel is 1, and code 5 holds while it is 0.
- R4: An edge is a change of the selected channel since the previous clock cycle. Code 1 detects a rise, code 2 a fall, and codes 3 and 7 either direction. A detected edge holds in the cycle it occurs.
- R5: A detected edge stays latched in its slice until the product term that contains the slice matches, or until the configuration register is written. A configuration write in the same cycle as an edge discards that edge.
- R6: `wrData[n]` of a configuration write is the end-point flag of slice n, for n from 0 to 6. Slice 7 is always an end point. A product term is the AND of all slices from the one after the previous end point up to its end point.
- R7: `termStatus[k]` shows the term that ends at slice k, and it is 0 when slice k is not an end point. `matchOut` is the OR of all terms.
- R8: A write with `wrAddr`=2 sets `patternSel` from `wrData[0]` and the event enable from `wrData[1]`.
- R9: `eventPulse` is 1 for exactly the cycle in which `matchOut` rises from its value in the previous cycle, and only while both control bits are set.
- R10: Register contents change only on writes. A write with `wrAddr`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chanIn | input | 8 | Synchronized input channels |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 source, 1 configuration, 2 control |
| wrData | input | 32 | Write data |
| patternSel | output | 1 | Interrupt path uses the pattern result |
| matchOut | output | 1 | OR of all product terms |
| termStatus | output | 8 | Match state of the term ending at each slice |
| eventPulse | output | 1 | One-cycle pulse on a rising match |

## Verification
The assertions check, on every cycle, the facts that hold one slice or one cycle at a time. The constant and level codes must follow the selected input. A cleared sticky latch must read empty on the next cycle. Status may appear only at end-point positions. The event pulse must be gated by both control bits and must never last two cycles. Writes to the unused address and idle cycles must leave the registers untouched. Only the bench scenarios can show the sequential behaviour across slices: an edge latched in one slice waits for a level in another, a term match or a configuration rewrite clears that latch, and several terms combine into the OR. These are compared against a behavioural model over directed and random register programs.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [2:0] {
    CondOne    = 3'd0,
    CondRise   = 3'd1,
    CondFall   = 3'd2,
    CondEither = 3'd3,
    CondHigh   = 3'd4,
    CondLow    = 3'd5,
    CondZero   = 3'd6,
    CondEvent  = 3'd7
  } cond_e;

  localparam int COND_W = 3;

  localparam logic [1:0] ADDR_SRC  = 2'd0;
  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic stickyClr;
    logic patternOn;
    logic eventOn;
  } pmStrobe_t;
endpackage

// File: rtl/pm_ctrl.sv
module pm_ctrl import pm_pkg::*; #(
  parameter int NUM_CH     = 8,
  parameter int NUM_SLICE  = 8,
  parameter int FIELD_BASE = 8,
  parameter int DATA_W     = 32,
  localparam int CH_W      = $clog2(NUM_CH)
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 wrEn,
  input  logic [1:0]                           wrAddr,
  input  logic [DATA_W-1:0]                    wrData,
  output logic [NUM_SLICE-1:0][CH_W-1:0]       srcSel,
  output logic [NUM_SLICE-1:0][COND_W-1:0]     condSel,
  output logic [NUM_SLICE-1:0]                 endMask,
  output pmStrobe_t                            strobe
);
  logic [NUM_SLICE-1:0][CH_W-1:0]   srcQ;
  logic [NUM_SLICE-1:0][COND_W-1:0] condQ;
  logic [NUM_SLICE-2:0]             endQ;
  logic [1:0]                       ctrlQ;
  logic                             unusedData;

  assign unusedData = ^wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ  <= '0;
      condQ <= '0;
      endQ  <= '0;
      ctrlQ <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_SRC:
          for (int n = 0; n < NUM_SLICE; n++)
            srcQ[n] <= wrData[FIELD_BASE + CH_W*n +: CH_W];
        ADDR_CFG: begin
          for (int n = 0; n < NUM_SLICE; n++)
            condQ[n] <= wrData[FIELD_BASE + COND_W*n +: COND_W];
          endQ <= wrData[NUM_SLICE-2:0];
        end
        ADDR_CTRL: ctrlQ <= wrData[1:0];
        default: ;
      endcase
    end
  end

  assign srcSel  = srcQ;
  assign condSel = condQ;
  assign endMask = {1'b1, endQ};

  assign strobe.stickyClr = wrEn && (wrAddr == ADDR_CFG);
  assign strobe.patternOn = ctrlQ[0];
  assign strobe.eventOn   = ctrlQ[1];

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(ctrlQ) && $stable(srcQ) && $stable(condQ)); // R10
  AST_ADDR3_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd3) |=> $stable(ctrlQ) && $stable(endQ) && $stable(condQ)); // R10
endmodule

// File: rtl/pm_slice.sv
module pm_slice import pm_pkg::*; #(
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CH-1:0]  chanNow,
  input  logic [NUM_CH-1:0]  chanPrev,
  input  logic [CH_W-1:0]    srcSel,
  input  logic [COND_W-1:0]  condCode,
  input  logic               clearIn,
  output logic               hit
);
  cond_e cond;
  logic  inBit, prevBit, edgeNow, isEdgeCode, stickyQ;

  assign cond    = cond_e'(condCode);
  assign inBit   = chanNow[srcSel];
  assign prevBit = chanPrev[srcSel];

  always_comb begin
    edgeNow    = 1'b0;
    isEdgeCode = 1'b0;
    case (cond)
      CondRise:             begin edgeNow = inBit & ~prevBit; isEdgeCode = 1'b1; end
      CondFall:             begin edgeNow = ~inBit & prevBit; isEdgeCode = 1'b1; end
      CondEither, CondEvent: begin edgeNow = inBit ^ prevBit; isEdgeCode = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    case (cond)
      CondOne:  hit = 1'b1;
      CondHigh: hit = inBit;
      CondLow:  hit = ~inBit;
      CondZero: hit = 1'b0;
      default:  hit = stickyQ | edgeNow;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       stickyQ <= 1'b0;
    else if (clearIn || !isEdgeCode) stickyQ <= 1'b0;
    else                             stickyQ <= stickyQ | edgeNow;
  end

  AST_CONST_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (cond == CondOne) |-> hit); // R3
  AST_CONST_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cond == CondZero) |-> !hit); // R3
  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (cond == CondHigh) |-> (hit == chanNow[srcSel])); // R3
  AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |=> !stickyQ); // R5
endmodule

// File: rtl/pm_datapath.sv
module pm_datapath import pm_pkg::*; #(
  parameter int NUM_CH    = 8,
  parameter int NUM_SLICE = 8,
  localparam int CH_W     = $clog2(NUM_CH)
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_CH-1:0]                chanIn,
  input  logic [NUM_SLICE-1:0][CH_W-1:0]   srcSel,
  input  logic [NUM_SLICE-1:0][COND_W-1:0] condSel,
  input  logic [NUM_SLICE-1:0]             endMask,
  input  pmStrobe_t                        strobe,
  output logic [NUM_SLICE-1:0]             termMatch,
  output logic                             matchOut,
  output logic                             eventPulse
);
  logic [NUM_CH-1:0]    chanPrevQ;
  logic                 matchPrevQ;
  logic [NUM_SLICE-1:0] sliceHit;
  logic [NUM_SLICE-1:0] ownMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanPrevQ  <= '0;
      matchPrevQ <= 1'b0;
    end else begin
      chanPrevQ  <= chanIn;
      matchPrevQ <= matchOut;
    end
  end

  for (genvar n = 0; n < NUM_SLICE; n++) begin : gSlice
    pm_slice #(.NUM_CH(NUM_CH)) slice_i (
      .clk      (clk),
      .rstN     (rstN),
      .chanNow  (chanIn),
      .chanPrev (chanPrevQ),
      .srcSel   (srcSel[n]),
      .condCode (condSel[n]),
      .clearIn  (strobe.stickyClr | ownMatch[n]),
      .hit      (sliceHit[n])
    );
  end

  // product terms: running AND restarted after each end point
  always_comb begin
    logic acc;
    acc = 1'b1;
    for (int n = 0; n < NUM_SLICE; n++) begin
      acc          = acc & sliceHit[n];
      termMatch[n] = endMask[n] & acc;
      if (endMask[n]) acc = 1'b1;
    end
  end

  // each slice sees the match of the term it belongs to
  always_comb begin
    logic own;
    own = 1'b0;
    for (int n = NUM_SLICE-1; n >= 0; n--) begin
      if (endMask[n]) own = termMatch[n];
      ownMatch[n] = own;
    end
  end

  assign matchOut   = |termMatch;
  assign eventPulse = matchOut & ~matchPrevQ & strobe.patternOn & strobe.eventOn;

  AST_TERM_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    (termMatch & ~endMask) == '0); // R7
  AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    eventPulse |=> !eventPulse); // R9
  AST_EVT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    eventPulse |-> (strobe.patternOn && strobe.eventOn && matchOut)); // R8
endmodule

// File: rtl/pm_engine.sv
module pm_engine import pm_pkg::*; #(
  parameter int NUM_CH     = 8,
  parameter int NUM_SLICE  = 8,
  parameter int FIELD_BASE = 8,
  parameter int DATA_W     = 32,
  localparam int CH_W      = $clog2(NUM_CH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CH-1:0]    chanIn,
  input  logic                 wrEn,
  input  logic [1:0]           wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  output logic                 patternSel,
  output logic                 matchOut,
  output logic [NUM_SLICE-1:0] termStatus,
  output logic                 eventPulse
);
  logic [NUM_SLICE-1:0][CH_W-1:0]   srcSel;
  logic [NUM_SLICE-1:0][COND_W-1:0] condSel;
  logic [NUM_SLICE-1:0]             endMask;
  pmStrobe_t                        strobe;

  pm_ctrl #(
    .NUM_CH(NUM_CH), .NUM_SLICE(NUM_SLICE),
    .FIELD_BASE(FIELD_BASE), .DATA_W(DATA_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .srcSel(srcSel), .condSel(condSel), .endMask(endMask), .strobe(strobe)
  );

  pm_datapath #(.NUM_CH(NUM_CH), .NUM_SLICE(NUM_SLICE)) dp_i (
    .clk(clk), .rstN(rstN), .chanIn(chanIn),
    .srcSel(srcSel), .condSel(condSel), .endMask(endMask), .strobe(strobe),
    .termMatch(termStatus), .matchOut(matchOut), .eventPulse(eventPulse)
  );

  assign patternSel = strobe.patternOn;
endmodule

// File: tb/pm_engine_tb_top.sv
module pm_engine_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  chanIn = '0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        patternSel, matchOut, eventPulse;
  logic [7:0]  termStatus;

  always #10 clk = ~clk; // 50 MHz

  pm_engine dut_i (
    .clk(clk), .rstN(rstN), .chanIn(chanIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .patternSel(patternSel), .matchOut(matchOut),
    .termStatus(termStatus), .eventPulse(eventPulse)
  );

  int checks = 0;
  int fails = 0;
  string curReq = "R1";

  // behavioural reference
  int mSrc[8];
  int mCode[8];
  bit mEnd[8];
  bit mPat, mEvt, mMatchPrev;
  bit [7:0] mPrev;
  bit mSticky[8];
  bit eEdge[8];
  bit [7:0] eTerm;
  bit eMatch, ePulse;

  function void modelReset();
    for (int n = 0; n < 8; n++) begin
      mSrc[n] = 0; mCode[n] = 0; mEnd[n] = (n == 7); mSticky[n] = 0;
    end
    mPat = 0; mEvt = 0; mMatchPrev = 0; mPrev = '0;
  endfunction

  function void modelEval();
    bit hitV[8];
    bit run;
    for (int n = 0; n < 8; n++) begin
      bit cur, pr;
      cur = chanIn[mSrc[n]];
      pr  = mPrev[mSrc[n]];
      eEdge[n] = 0;
      if (mCode[n] == 1) eEdge[n] = cur && !pr;
      if (mCode[n] == 2) eEdge[n] = !cur && pr;
      if (mCode[n] == 3 || mCode[n] == 7) eEdge[n] = cur != pr;
      case (mCode[n])
        0: hitV[n] = 1;
        4: hitV[n] = cur;
        5: hitV[n] = !cur;
        6: hitV[n] = 0;
        default: hitV[n] = mSticky[n] || eEdge[n];
      endcase
    end
    run = 1;
    eTerm = '0;
    for (int n = 0; n < 8; n++) begin
      run = run && hitV[n];
      if (mEnd[n]) begin
        eTerm[n] = run;
        run = 1;
      end
    end
    eMatch = |eTerm;
    ePulse = eMatch && !mMatchPrev && mPat && mEvt;
  endfunction

  function void modelCommit();
    for (int n = 0; n < 8; n++) begin
      bit own;
      int k;
      k = n;
      while (!mEnd[k]) k++;
      own = eTerm[k];
      if (wrEn && wrAddr == 2'd1) mSticky[n] = 0;
      else if (mCode[n] inside {1, 2, 3, 7}) mSticky[n] = own ? 0 : (mSticky[n] || eEdge[n]);
      else mSticky[n] = 0;
    end
    mPrev = chanIn;
    mMatchPrev = eMatch;
    if (wrEn) begin
      case (wrAddr)
        2'd0: for (int n = 0; n < 8; n++) mSrc[n] = int'(wrData[8+3*n +: 3]);
        2'd1: for (int n = 0; n < 8; n++) begin
                mCode[n] = int'(wrData[8+3*n +: 3]);
                mEnd[n]  = (n == 7) ? 1'b1 : wrData[n];
              end
        2'd2: begin mPat = wrData[0]; mEvt = wrData[1]; end
        default: ;
      endcase
    end
  endfunction

  task automatic compareAll();
    checks++;
    if (termStatus !== eTerm || matchOut !== eMatch || eventPulse !== ePulse ||
        patternSel !== mPat) begin
      fails++;
      $display("FAIL %s: term=%h match=%b pulse=%b sel=%b expected term=%h match=%b pulse=%b sel=%b",
               curReq, termStatus, matchOut, eventPulse, patternSel,
               eTerm, eMatch, ePulse, mPat);
    end
  endtask

  task automatic step(input logic [7:0] inV, input logic we = 1'b0,
                      input logic [1:0] a = 2'd0, input logic [31:0] d = '0);
    chanIn = inV; wrEn = we; wrAddr = a; wrData = d;
    @(negedge clk);
    modelEval();
    compareAll();
    @(posedge clk);
    modelCommit();
    #2;
    wrEn = 1'b0;
  endtask

  // slice values given slice7 first
  function automatic logic [31:0] mkField(input logic [7:0][2:0] v, input logic [6:0] e);
    logic [31:0] d;
    d = '0;
    for (int n = 0; n < 8; n++) d[8+3*n +: 3] = v[n];
    d[6:0] = e;
    return d;
  endfunction

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    // R1: reset state
    curReq = "R1";
    @(negedge clk); modelEval(); compareAll();
    checks++;
    if (termStatus !== 8'h80 || matchOut !== 1'b1) begin
      fails++;
      $display("FAIL R1: term=%h match=%b expected term=80 match=1", termStatus, matchOut);
    end
    @(posedge clk); modelCommit(); #2;

    // R2 R3: high level on channel 3 in slice 0
    curReq = "R2";
    step(8'h00, 1, 2'd0, mkField({3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd3}, 7'd0));
    curReq = "R3";
    step(8'h00, 1, 2'd1, mkField({3'd6,3'd6,3'd6,3'd6,3'd6,3'd6,3'd6,3'd4}, 7'h01));
    step(8'h08); step(8'h00); step(8'hF7); step(8'hFF);
    step(8'h00, 1, 2'd1, mkField({3'd6,3'd6,3'd6,3'd6,3'd6,3'd6,3'd6,3'd5}, 7'h01));
    step(8'h00); step(8'h08); step(8'h00);

    // R4: rise, fall, either, event on channel 3
    curReq = "R4";
    for (int c = 1; c <= 7; c++) begin
      if (c == 4) c = 7;
      step(8'h00, 1, 2'd1, mkField({3'd6,3'd6,3'd6,3'd6,3'd6,3'd6,3'd6,3'(c)}, 7'h01));
      step(8'h08); step(8'h08); step(8'h00); step(8'h00); step(8'h08);
    end

    // R5: rising edge on ch1 waits for high level on ch2
    curReq = "R5";
    step(8'h00, 1, 2'd0, mkField({3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd2,3'd1}, 7'd0));
    step(8'h00, 1, 2'd1, mkField({3'd6,3'd6,3'd6,3'd6,3'd6,3'd6,3'd4,3'd1}, 7'h02));
    step(8'h02); step(8'h00); step(8'h00); step(8'h04); step(8'h04); step(8'h00);
    step(8'h02); step(8'h06); step(8'h06);
    step(8'h00); step(8'h02);
    step(8'h02, 1, 2'd1, mkField({3'd6,3'd6,3'd6,3'd6,3'd6,3'd6,3'd4,3'd1}, 7'h02));
    step(8'h06); step(8'h04);
    step(8'h01, 1, 2'd1, mkField({3'd6,3'd6,3'd6,3'd6,3'd6,3'd6,3'd4,3'd1}, 7'h02));
    step(8'h07); step(8'h04);

    // R6 R7: three terms, slice n watches channel n
    curReq = "R6";
    step(8'h00, 1, 2'd0, mkField({3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}, 7'd0));
    step(8'h00, 1, 2'd1, mkField({3'd4,3'd0,3'd0,3'd0,3'd0,3'd5,3'd4,3'd4}, 7'h06));
    curReq = "R7";
    step(8'h03); step(8'h07); step(8'h84); step(8'h83); step(8'h01); step(8'h80);

    // R8 R9: control bits and event pulse
    curReq = "R8";
    step(8'h04, 1, 2'd2, 32'h1);
    step(8'h07); step(8'h04);
    curReq = "R9";
    step(8'h04, 1, 2'd2, 32'h3);
    step(8'h07); step(8'h07); step(8'h04); step(8'h03); step(8'h87); step(8'h04);
    step(8'h04, 1, 2'd2, 32'h2);
    step(8'h03); step(8'h04);

    // R10: address 3 ignored, idle cycles hold state
    curReq = "R10";
    step(8'h04, 1, 2'd3, 32'hFFFF_FFFF);
    step(8'h03); step(8'h04); step(8'h80);

    // mixed random programs
    curReq = "R7";
    for (int i = 0; i < 600; i++) begin
      if (i % 12 == 0) step(8'($urandom), 1, 2'($urandom), $urandom);
      else step(8'($urandom & ((i % 3 == 0) ? 32'hFF : 32'h0F)));
    end

    finishRun();
  end
endmodule